// File: doc/BRIEF.md
# Store-to-Load Forwarding Lookup

This block holds the address and data state of a small store queue and answers forwarding queries from a two-stage load pipeline. Each entry records a virtual line address, a physical line address, a byte-enable mask over the data word, the store data, and two flags. One flag says the address is known. The other says the data has arrived. Three write ports fill and retire entries: an address write, a data write and an entry clear.

A load presents its virtual and physical line addresses, its byte mask, and a bit-per-entry vector marking the stores older than itself. The requester computes that vector one stage earlier, so the block itself never compares queue pointers.

The response comes in two stages. In the query cycle the block returns a fast byte-hit hint built from the virtual match. One cycle later it returns registered results built from the physical match:
- the full forward mask and the forwarded bytes;
- a data-not-ready replay flag, with the index of the culprit entry;
- an address-unknown replay flag, with the index of the culprit entry;
- a flag raised when the virtual and physical matches disagree, which asks for a flush.

Top module: `stlf_lookup`

## Requirements
- R1: After reset every entry has both flags clear and every output is zero.
- R2: An address write stores the two line addresses and the byte mask of an entry and sets its address flag, without touching its data flag. A data write stores the data and sets the data flag. A clear drops both flags. When a clear and a write hit the same entry in one cycle, the write is applied after the clear. A write is seen by queries from the cycle after it.
- R3: An entry takes part in a query only when its bit in `q_older` is set and its address flag is set. It hits byte lane j when its line address equals the query's line address and both byte masks have bit j set. Lane j covers data bits [8j+7:8j].
- R4: `fast_mask` is combinational in the query cycle. Bit j is set when some taking-part entry hits lane j on the virtual line address and has its data flag set.
- R5: In the cycle after a query, `fwd_mask` and `fwd_data` are valid. For each lane the block picks the physically hitting entry with the highest index, which is taken as the youngest. If that entry has data, the lane's mask bit is set and its byte is forwarded. Otherwise the mask bit is 0. Data lanes whose mask bit is 0 read as zero.
- R6: `data_inv` is set in the cycle after a query when the entry picked for any lane lacks data. `data_inv_idx` is then the highest such picked index, and it is 0 when the flag is clear.
- R7: `addr_inv` is set in the cycle after a query when an entry marked in `q_older` has its address flag clear. `addr_inv_idx` is then the highest such index, and it is 0 when the flag is clear.
- R8: `match_inv` is set in the cycle after a query when, for some taking-part entry, its set of virtually hit lanes differs from its set of physically hit lanes.
- R9: While `q_valid` is low, `fast_mask` is zero. In the following cycle every stage-2 output is zero.
- R10: Entries whose `q_older` bit is clear have no effect on any output, whatever their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| aw_en | input | 1 | Address write strobe |
| aw_idx | input | IDX_W | Entry written by the address port |
| aw_vline | input | VA_W-OFF_W | Virtual line address |
| aw_pline | input | PA_W-OFF_W | Physical line address |
| aw_mask | input | LANES | Store byte mask |
| dw_en | input | 1 | Data write strobe |
| dw_idx | input | IDX_W | Entry written by the data port |
| dw_data | input | DATA_W | Store data |
| clr_en | input | 1 | Entry clear strobe |
| clr_idx | input | IDX_W | Entry to clear |
| q_valid | input | 1 | Query present in this cycle |
| q_vline | input | VA_W-OFF_W | Load virtual line address |
| q_pline | input | PA_W-OFF_W | Load physical line address |
| q_mask | input | LANES | Load byte mask |
| q_older | input | N_ENTRIES | Entries older than the load |
| fast_mask | output | LANES | Stage-1 byte-hit hint |
| fwd_mask | output | LANES | Stage-2 forwarded lanes |
| fwd_data | output | DATA_W | Stage-2 forwarded bytes |
| data_inv | output | 1 | Data-not-ready replay request |
| data_inv_idx | output | IDX_W | Culprit of data_inv |
| addr_inv | output | 1 | Address-unknown replay request |
| addr_inv_idx | output | IDX_W | Culprit of addr_inv |
| match_inv | output | 1 | Virtual/physical disagreement, flush request |

## Verification
The assertions assume that `q_older` names the older entries the requester computed. They also assume that the query inputs are held steady across the cycle they are sampled, so `$past` of the mask and the older vector describes the query behind each stage-2 result. The stimulus drives every input one half-cycle before the capturing edge and keeps it constant through that edge. The stimulus sweeps all sixteen older vectors over several stored-entry layouts, including entries with no data, entries with no address, and entries whose two line addresses disagree. The sweeps also cover a clear and an address write landing together, and a data write issued in the same cycle as a query.

// File: rtl/stlf_pkg.sv
package stlf_pkg;
   localparam int unsigned BYTE_W = 8;

   function automatic int unsigned lanes_of(input int unsigned data_w);
      return data_w / BYTE_W;
   endfunction
endpackage

// File: rtl/stlf_entry_store.sv
module stlf_entry_store #(
   parameter int unsigned N_ENTRIES = 16,
   parameter int unsigned VLN_W     = 35,
   parameter int unsigned PLN_W     = 32,
   parameter int unsigned LANES     = 16,
   parameter int unsigned DATA_W    = 128,
   parameter int unsigned IDX_W     = 4
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  aw_en,
   input  logic [IDX_W-1:0]                      aw_idx,
   input  logic [VLN_W-1:0]                      aw_vline,
   input  logic [PLN_W-1:0]                      aw_pline,
   input  logic [LANES-1:0]                      aw_mask,
   input  logic                                  dw_en,
   input  logic [IDX_W-1:0]                      dw_idx,
   input  logic [DATA_W-1:0]                     dw_data,
   input  logic                                  clr_en,
   input  logic [IDX_W-1:0]                      clr_idx,
   output logic [N_ENTRIES-1:0][VLN_W-1:0]       e_vline,
   output logic [N_ENTRIES-1:0][PLN_W-1:0]       e_pline,
   output logic [N_ENTRIES-1:0][LANES-1:0]       e_mask,
   output logic [N_ENTRIES-1:0][DATA_W-1:0]      e_data,
   output logic [N_ENTRIES-1:0]                  e_aval,
   output logic [N_ENTRIES-1:0]                  e_dval
);
   for (genvar e = 0; e < N_ENTRIES; e++) begin : g_ent
      logic hit_clr, hit_aw, hit_dw;
      assign hit_clr = clr_en && (clr_idx == IDX_W'(e));
      assign hit_aw  = aw_en  && (aw_idx  == IDX_W'(e));
      assign hit_dw  = dw_en  && (dw_idx  == IDX_W'(e));

      // flags: clear first, then writes, so a same-cycle write wins
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            e_aval[e] <= 1'b0;
            e_dval[e] <= 1'b0;
         end else begin
            if (hit_clr) begin
               e_aval[e] <= 1'b0;
               e_dval[e] <= 1'b0;
            end
            if (hit_aw) e_aval[e] <= 1'b1;
            if (hit_dw) e_dval[e] <= 1'b1;
         end
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            e_vline[e] <= '0;
            e_pline[e] <= '0;
            e_mask[e]  <= '0;
            e_data[e]  <= '0;
         end else begin
            if (hit_aw) begin
               e_vline[e] <= aw_vline;
               e_pline[e] <= aw_pline;
               e_mask[e]  <= aw_mask;
            end
            if (hit_dw) e_data[e] <= dw_data;
         end
      end
   end
endmodule

// File: rtl/stlf_match.sv
module stlf_match #(
   parameter int unsigned N_ENTRIES = 16,
   parameter int unsigned VLN_W     = 35,
   parameter int unsigned PLN_W     = 32,
   parameter int unsigned LANES     = 16
) (
   input  logic [N_ENTRIES-1:0][VLN_W-1:0] e_vline,
   input  logic [N_ENTRIES-1:0][PLN_W-1:0] e_pline,
   input  logic [N_ENTRIES-1:0][LANES-1:0] e_mask,
   input  logic [N_ENTRIES-1:0]            e_aval,
   input  logic [N_ENTRIES-1:0]            q_older,
   input  logic [VLN_W-1:0]                q_vline,
   input  logic [PLN_W-1:0]                q_pline,
   input  logic [LANES-1:0]                q_mask,
   output logic [N_ENTRIES-1:0][LANES-1:0] va_hit,
   output logic [N_ENTRIES-1:0][LANES-1:0] pa_hit
);
   for (genvar e = 0; e < N_ENTRIES; e++) begin : g_cmp
      logic        live;
      logic [LANES-1:0] overlap;
      assign live    = q_older[e] & e_aval[e];
      assign overlap = e_mask[e] & q_mask;
      assign va_hit[e] = (live && (e_vline[e] == q_vline)) ? overlap : '0;
      assign pa_hit[e] = (live && (e_pline[e] == q_pline)) ? overlap : '0;
   end
endmodule

// File: rtl/stlf_lane_select.sv
module stlf_lane_select
   import stlf_pkg::*;
#(
   parameter int unsigned N_ENTRIES = 16,
   parameter int unsigned LANES     = 16,
   parameter int unsigned DATA_W    = 128,
   parameter int unsigned IDX_W     = 4
) (
   input  logic [N_ENTRIES-1:0][LANES-1:0]  pa_hit,
   input  logic [N_ENTRIES-1:0]             e_dval,
   input  logic [N_ENTRIES-1:0][DATA_W-1:0] e_data,
   output logic [LANES-1:0]                 lane_fwd,
   output logic [DATA_W-1:0]                lane_data,
   output logic                             blk_any,
   output logic [IDX_W-1:0]                 blk_idx
);
   logic [LANES-1:0]            lane_blk;
   logic [LANES-1:0][IDX_W-1:0] lane_sel;

   for (genvar j = 0; j < LANES; j++) begin : g_lane
      logic [IDX_W-1:0] sel;
      logic             hit;
      // ascending scan: the last hit is the highest (youngest) index
      always_comb begin
         sel = '0;
         hit = 1'b0;
         for (int e = 0; e < N_ENTRIES; e++) begin
            if (pa_hit[e][j]) begin
               sel = IDX_W'(e);
               hit = 1'b1;
            end
         end
      end
      assign lane_sel[j] = sel;
      assign lane_fwd[j] = hit &  e_dval[sel];
      assign lane_blk[j] = hit & ~e_dval[sel];
      assign lane_data[j*BYTE_W +: BYTE_W] =
         lane_fwd[j] ? e_data[sel][j*BYTE_W +: BYTE_W] : '0;
   end

   always_comb begin
      blk_any = 1'b0;
      blk_idx = '0;
      for (int j = 0; j < LANES; j++) begin
         if (lane_blk[j] && (!blk_any || lane_sel[j] > blk_idx)) begin
            blk_idx = lane_sel[j];
            blk_any = 1'b1;
         end
      end
   end
endmodule

// File: rtl/stlf_lookup.sv
module stlf_lookup
   import stlf_pkg::*;
#(
   parameter int unsigned N_ENTRIES       = 16,
   parameter int unsigned VA_W            = 39,
   parameter int unsigned PA_W            = 36,
   parameter int unsigned DATA_W          = 128,
   parameter bit          FAST_NEEDS_DATA = 1'b1,
   localparam int unsigned LANES = lanes_of(DATA_W),
   localparam int unsigned OFF_W = $clog2(LANES),
   localparam int unsigned VLN_W = VA_W - OFF_W,
   localparam int unsigned PLN_W = PA_W - OFF_W,
   localparam int unsigned IDX_W = $clog2(N_ENTRIES)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 aw_en,
   input  logic [IDX_W-1:0]     aw_idx,
   input  logic [VLN_W-1:0]     aw_vline,
   input  logic [PLN_W-1:0]     aw_pline,
   input  logic [LANES-1:0]     aw_mask,
   input  logic                 dw_en,
   input  logic [IDX_W-1:0]     dw_idx,
   input  logic [DATA_W-1:0]    dw_data,
   input  logic                 clr_en,
   input  logic [IDX_W-1:0]     clr_idx,
   input  logic                 q_valid,
   input  logic [VLN_W-1:0]     q_vline,
   input  logic [PLN_W-1:0]     q_pline,
   input  logic [LANES-1:0]     q_mask,
   input  logic [N_ENTRIES-1:0] q_older,
   output logic [LANES-1:0]     fast_mask,
   output logic [LANES-1:0]     fwd_mask,
   output logic [DATA_W-1:0]    fwd_data,
   output logic                 data_inv,
   output logic [IDX_W-1:0]     data_inv_idx,
   output logic                 addr_inv,
   output logic [IDX_W-1:0]     addr_inv_idx,
   output logic                 match_inv
);
   if (N_ENTRIES < 2)                  begin : g_bad_n   $error("N_ENTRIES must be at least 2"); end
   if (DATA_W % BYTE_W != 0)           begin : g_bad_dw  $error("DATA_W must be whole bytes"); end
   if ((LANES & (LANES - 1)) != 0)     begin : g_bad_ln  $error("lane count must be a power of two"); end
   if (VA_W <= OFF_W || PA_W <= OFF_W) begin : g_bad_aw  $error("address narrower than line offset"); end

   logic [N_ENTRIES-1:0][VLN_W-1:0]  e_vline;
   logic [N_ENTRIES-1:0][PLN_W-1:0]  e_pline;
   logic [N_ENTRIES-1:0][LANES-1:0]  e_mask;
   logic [N_ENTRIES-1:0][DATA_W-1:0] e_data;
   logic [N_ENTRIES-1:0]             e_aval, e_dval;
   logic [N_ENTRIES-1:0][LANES-1:0]  va_hit, pa_hit;

   stlf_entry_store #(
      .N_ENTRIES(N_ENTRIES), .VLN_W(VLN_W), .PLN_W(PLN_W),
      .LANES(LANES), .DATA_W(DATA_W), .IDX_W(IDX_W)
   ) store_i (
      .clk(clk), .rst_n(rst_n),
      .aw_en(aw_en), .aw_idx(aw_idx), .aw_vline(aw_vline),
      .aw_pline(aw_pline), .aw_mask(aw_mask),
      .dw_en(dw_en), .dw_idx(dw_idx), .dw_data(dw_data),
      .clr_en(clr_en), .clr_idx(clr_idx),
      .e_vline(e_vline), .e_pline(e_pline), .e_mask(e_mask),
      .e_data(e_data), .e_aval(e_aval), .e_dval(e_dval)
   );

   stlf_match #(
      .N_ENTRIES(N_ENTRIES), .VLN_W(VLN_W), .PLN_W(PLN_W), .LANES(LANES)
   ) match_i (
      .e_vline(e_vline), .e_pline(e_pline), .e_mask(e_mask), .e_aval(e_aval),
      .q_older(q_older), .q_vline(q_vline), .q_pline(q_pline), .q_mask(q_mask),
      .va_hit(va_hit), .pa_hit(pa_hit)
   );

   logic [LANES-1:0]  s1_fwd;
   logic [DATA_W-1:0] s1_data;
   logic              s1_blk;
   logic [IDX_W-1:0]  s1_blk_idx;

   stlf_lane_select #(
      .N_ENTRIES(N_ENTRIES), .LANES(LANES), .DATA_W(DATA_W), .IDX_W(IDX_W)
   ) sel_i (
      .pa_hit(pa_hit), .e_dval(e_dval), .e_data(e_data),
      .lane_fwd(s1_fwd), .lane_data(s1_data),
      .blk_any(s1_blk), .blk_idx(s1_blk_idx)
   );

   // stage-1 hint from the virtual match
   logic [N_ENTRIES-1:0] fast_qual;
   if (FAST_NEEDS_DATA) begin : g_fast_data
      assign fast_qual = e_dval;
   end else begin : g_fast_addr
      assign fast_qual = '1;
   end

   always_comb begin
      fast_mask = '0;
      if (q_valid) begin
         for (int e = 0; e < N_ENTRIES; e++) begin
            if (fast_qual[e]) fast_mask = fast_mask | va_hit[e];
         end
      end
   end

   logic             s1_ainv, s1_minv;
   logic [IDX_W-1:0] s1_ainv_idx;

   always_comb begin
      s1_ainv     = 1'b0;
      s1_ainv_idx = '0;
      s1_minv     = 1'b0;
      for (int e = 0; e < N_ENTRIES; e++) begin
         if (q_older[e] && !e_aval[e]) begin
            s1_ainv     = 1'b1;
            s1_ainv_idx = IDX_W'(e);
         end
         if (va_hit[e] != pa_hit[e]) s1_minv = 1'b1;
      end
   end

   // stage 2: results of the stage-1 comparison, zero when no query
   always_ff @(posedge clk) begin
      if (!rst_n || !q_valid) begin
         fwd_mask     <= '0;
         fwd_data     <= '0;
         data_inv     <= 1'b0;
         data_inv_idx <= '0;
         addr_inv     <= 1'b0;
         addr_inv_idx <= '0;
         match_inv    <= 1'b0;
      end else begin
         fwd_mask     <= s1_fwd;
         fwd_data     <= s1_data;
         data_inv     <= s1_blk;
         data_inv_idx <= s1_blk_idx;
         addr_inv     <= s1_ainv;
         addr_inv_idx <= s1_ainv_idx;
         match_inv    <= s1_minv;
      end
   end
endmodule

// File: rtl/stlf_lookup_chk.sv
module stlf_lookup_chk #(
   parameter int unsigned N_ENTRIES = 16,
   parameter int unsigned LANES     = 16,
   parameter int unsigned DATA_W    = 128,
   parameter int unsigned IDX_W     = 4
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 q_valid,
   input logic [LANES-1:0]     q_mask,
   input logic [N_ENTRIES-1:0] q_older,
   input logic [LANES-1:0]     fast_mask,
   input logic [LANES-1:0]     fwd_mask,
   input logic [DATA_W-1:0]    fwd_data,
   input logic                 data_inv,
   input logic [IDX_W-1:0]     data_inv_idx,
   input logic                 addr_inv,
   input logic [IDX_W-1:0]     addr_inv_idx,
   input logic                 match_inv
);
   localparam logic [N_ENTRIES-1:0] ONE = N_ENTRIES'(1);

   a_r9_idle_fast: assert property (@(posedge clk) disable iff (!rst_n)
      !q_valid |-> fast_mask == '0);

   a_r9_idle_stage2: assert property (@(posedge clk) disable iff (!rst_n)
      !q_valid |=> (fwd_mask == '0 && fwd_data == '0 && !data_inv && !addr_inv && !match_inv));

   a_r4_fast_within_load: assert property (@(posedge clk) disable iff (!rst_n)
      (fast_mask & ~q_mask) == '0);

   a_r5_fwd_within_load: assert property (@(posedge clk) disable iff (!rst_n)
      q_valid |=> (fwd_mask & ~$past(q_mask)) == '0);

   a_r10_none_older: assert property (@(posedge clk) disable iff (!rst_n)
      (q_valid && q_older == '0) |=> (fwd_mask == '0 && !data_inv && !addr_inv && !match_inv));

   a_r6_culprit_older: assert property (@(posedge clk) disable iff (!rst_n)
      q_valid |=> (!data_inv || ((($past(q_older) >> data_inv_idx) & ONE) != '0)));

   a_r7_culprit_older: assert property (@(posedge clk) disable iff (!rst_n)
      q_valid |=> (!addr_inv || ((($past(q_older) >> addr_inv_idx) & ONE) != '0)));

   for (genvar j = 0; j < LANES; j++) begin : g_lane_chk
      a_r5_unmasked_zero: assert property (@(posedge clk) disable iff (!rst_n)
         !fwd_mask[j] |-> fwd_data[j*8 +: 8] == 8'h00);
   end
endmodule

bind stlf_lookup stlf_lookup_chk #(
   .N_ENTRIES(N_ENTRIES), .LANES(LANES), .DATA_W(DATA_W), .IDX_W(IDX_W)
) chk_i (
   .clk(clk), .rst_n(rst_n), .q_valid(q_valid), .q_mask(q_mask), .q_older(q_older),
   .fast_mask(fast_mask), .fwd_mask(fwd_mask), .fwd_data(fwd_data),
   .data_inv(data_inv), .data_inv_idx(data_inv_idx),
   .addr_inv(addr_inv), .addr_inv_idx(addr_inv_idx), .match_inv(match_inv)
);

// File: tb/stlf_lookup_tb.sv
`timescale 1ns/1ps
module stlf_lookup_tb_top;
   localparam int N = 4;
   localparam int L = 16;
   localparam int DW = 128;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic          aw_en = 0, dw_en = 0, clr_en = 0, q_valid = 0;
   logic [1:0]    aw_idx = 0, dw_idx = 0, clr_idx = 0;
   logic [7:0]    aw_vline = 0, aw_pline = 0, q_vline = 0, q_pline = 0;
   logic [L-1:0]  aw_mask = 0, q_mask = 0;
   logic [DW-1:0] dw_data = 0;
   logic [N-1:0]  q_older = 0;
   logic [L-1:0]  fast_mask, fwd_mask;
   logic [DW-1:0] fwd_data;
   logic          data_inv, addr_inv, match_inv;
   logic [1:0]    data_inv_idx, addr_inv_idx;

   stlf_lookup #(.N_ENTRIES(N), .VA_W(12), .PA_W(12), .DATA_W(DW)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .aw_en(aw_en), .aw_idx(aw_idx), .aw_vline(aw_vline), .aw_pline(aw_pline), .aw_mask(aw_mask),
      .dw_en(dw_en), .dw_idx(dw_idx), .dw_data(dw_data),
      .clr_en(clr_en), .clr_idx(clr_idx),
      .q_valid(q_valid), .q_vline(q_vline), .q_pline(q_pline), .q_mask(q_mask), .q_older(q_older),
      .fast_mask(fast_mask), .fwd_mask(fwd_mask), .fwd_data(fwd_data),
      .data_inv(data_inv), .data_inv_idx(data_inv_idx),
      .addr_inv(addr_inv), .addr_inv_idx(addr_inv_idx), .match_inv(match_inv)
   );

   int n_chk = 0;
   int n_bad = 0;

   // shadow of what the bench wrote
   logic [7:0]    sh_vl [N];
   logic [7:0]    sh_pl [N];
   logic [L-1:0]  sh_mk [N];
   logic [DW-1:0] sh_dt [N];
   logic          sh_av [N];
   logic          sh_dv [N];

   task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] pat(input int e, input int gen);
      logic [DW-1:0] d;
      for (int j = 0; j < L; j++) d[j*8 +: 8] = 8'(gen*64 + e*16 + j + 1);
      return d;
   endfunction

   task automatic wr_addr(input int e, input logic [7:0] vl, input logic [7:0] pl, input logic [L-1:0] m);
      @(negedge clk);
      aw_en = 1; aw_idx = 2'(e); aw_vline = vl; aw_pline = pl; aw_mask = m;
      @(negedge clk);
      aw_en = 0;
      sh_vl[e] = vl; sh_pl[e] = pl; sh_mk[e] = m; sh_av[e] = 1;
   endtask

   task automatic wr_data(input int e, input logic [DW-1:0] d);
      @(negedge clk);
      dw_en = 1; dw_idx = 2'(e); dw_data = d;
      @(negedge clk);
      dw_en = 0;
      sh_dt[e] = d; sh_dv[e] = 1;
   endtask

   // expected results computed from the requirements
   task automatic model(input logic [7:0] vl, input logic [7:0] pl, input logic [L-1:0] m,
                        input logic [N-1:0] old,
                        output logic [L-1:0] fst, output logic [L-1:0] fm, output logic [DW-1:0] fd,
                        output logic di, output logic [1:0] dix, output logic ai,
                        output logic [1:0] aix, output logic mi);
      int best;
      fst = '0; fm = '0; fd = '0; ai = 0; aix = 0; mi = 0; best = -1;
      for (int e = 0; e < N; e++) begin
         if (old[e] && !sh_av[e]) begin ai = 1; aix = 2'(e); end
         if (old[e] && sh_av[e]) begin
            logic [L-1:0] vh, ph;
            vh = (sh_vl[e] == vl) ? (sh_mk[e] & m) : '0;
            ph = (sh_pl[e] == pl) ? (sh_mk[e] & m) : '0;
            if (vh != ph) mi = 1;
            if (sh_dv[e]) fst = fst | vh;
         end
      end
      for (int j = 0; j < L; j++) begin
         int sel;
         sel = -1;
         for (int e = 0; e < N; e++)
            if (old[e] && sh_av[e] && sh_pl[e] == pl && sh_mk[e][j] && m[j]) sel = e;
         if (sel >= 0) begin
            if (sh_dv[sel]) begin
               fm[j] = 1;
               fd[j*8 +: 8] = sh_dt[sel][j*8 +: 8];
            end else if (sel > best) best = sel;
         end
      end
      di  = (best >= 0);
      dix = di ? 2'(best) : 2'd0;
   endtask

   task automatic check_s2(input logic [L-1:0] fm, input logic [DW-1:0] fd, input logic di,
                           input logic [1:0] dix, input logic ai, input logic [1:0] aix, input logic mi);
      check("R5 R3 R10 fwd_mask", DW'(fwd_mask), DW'(fm));
      check("R5 fwd_data", fwd_data, fd);
      check("R6 data_inv", DW'(data_inv), DW'(di));
      check("R6 data_inv_idx", DW'(data_inv_idx), DW'(dix));
      check("R7 addr_inv", DW'(addr_inv), DW'(ai));
      check("R7 addr_inv_idx", DW'(addr_inv_idx), DW'(aix));
      check("R8 match_inv", DW'(match_inv), DW'(mi));
   endtask

   task automatic run_query(input logic [7:0] vl, input logic [7:0] pl, input logic [L-1:0] m,
                            input logic [N-1:0] old);
      logic [L-1:0] e_fst, e_fm; logic [DW-1:0] e_fd;
      logic e_di, e_ai, e_mi; logic [1:0] e_dix, e_aix;
      model(vl, pl, m, old, e_fst, e_fm, e_fd, e_di, e_dix, e_ai, e_aix, e_mi);
      @(negedge clk);
      q_valid = 1; q_vline = vl; q_pline = pl; q_mask = m; q_older = old;
      #1 check("R4 R10 fast_mask", DW'(fast_mask), DW'(e_fst));
      @(negedge clk);
      q_valid = 0;
      check_s2(e_fm, e_fd, e_di, e_dix, e_ai, e_aix, e_mi);
   endtask

   task automatic sweep();
      for (int o = 0; o < 16; o++) begin
         run_query(8'h12, 8'h34, 16'hFFFF, 4'(o));
         run_query(8'h12, 8'h34, 16'h00F0, 4'(o));
         run_query(8'h12, 8'h34, 16'hF000, 4'(o));
         run_query(8'h13, 8'h35, 16'hFFFF, 4'(o));
      end
   endtask

   initial begin
      #800000;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      for (int e = 0; e < N; e++) begin
         sh_vl[e] = 0; sh_pl[e] = 0; sh_mk[e] = 0; sh_dt[e] = 0; sh_av[e] = 0; sh_dv[e] = 0;
      end
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 fast_mask", DW'(fast_mask), '0);
      check_s2('0, '0, 0, 0, 0, 0, 0);
      rst_n = 1;
      // R1: no entry holds an address yet, so all-older gives addr_inv at 3
      run_query(8'h12, 8'h34, 16'hFFFF, 4'hF);

      // layout A: overlapping stores, one lacking data, one lacking address
      wr_addr(0, 8'h12, 8'h34, 16'h00FF); wr_data(0, pat(0, 0));
      wr_addr(1, 8'h12, 8'h34, 16'h0FF0); wr_data(1, pat(1, 0));
      wr_addr(2, 8'h12, 8'h34, 16'h000F);
      sweep();

      // layout B: virtual/physical disagreement on entries 0 and 3; R2 address rewrite keeps data
      wr_data(2, pat(2, 1));
      wr_addr(3, 8'h12, 8'h35, 16'hF000); wr_data(3, pat(3, 1));
      wr_addr(0, 8'h22, 8'h34, 16'h00FF);
      sweep();

      // R9: no query, stage 1 and stage 2 stay zero
      @(negedge clk);
      q_valid = 0; q_vline = 8'h12; q_pline = 8'h34; q_mask = 16'hFFFF; q_older = 4'hF;
      #1 check("R9 fast_mask idle", DW'(fast_mask), '0);
      @(negedge clk);
      check_s2('0, '0, 0, 0, 0, 0, 0);

      // R2: clear alone, then clear and address write on one entry together
      @(negedge clk);
      clr_en = 1; clr_idx = 1;
      @(negedge clk);
      clr_en = 0; sh_av[1] = 0; sh_dv[1] = 0;
      @(negedge clk);
      clr_en = 1; clr_idx = 2; aw_en = 1; aw_idx = 2; aw_vline = 8'h12; aw_pline = 8'h34; aw_mask = 16'h0F00;
      @(negedge clk);
      clr_en = 0; aw_en = 0;
      sh_dv[2] = 0; sh_av[2] = 1; sh_vl[2] = 8'h12; sh_pl[2] = 8'h34; sh_mk[2] = 16'h0F00;
      for (int o = 0; o < 16; o++) run_query(8'h12, 8'h34, 16'hFFFF, 4'(o));

      // R2: a data write is not seen by a query in its own cycle
      begin
         logic [L-1:0] e_fst, e_fm; logic [DW-1:0] e_fd;
         logic e_di, e_ai, e_mi; logic [1:0] e_dix, e_aix;
         model(8'h12, 8'h34, 16'h0F00, 4'b0100, e_fst, e_fm, e_fd, e_di, e_dix, e_ai, e_aix, e_mi);
         @(negedge clk);
         dw_en = 1; dw_idx = 2; dw_data = pat(2, 2);
         q_valid = 1; q_vline = 8'h12; q_pline = 8'h34; q_mask = 16'h0F00; q_older = 4'b0100;
         #1 check("R2 same-cycle write unseen fast", DW'(fast_mask), DW'(e_fst));
         @(negedge clk);
         dw_en = 0; q_valid = 0;
         check("R2 same-cycle write data_inv", DW'(data_inv), 1);
         check_s2(e_fm, e_fd, e_di, e_dix, e_ai, e_aix, e_mi);
         sh_dt[2] = pat(2, 2); sh_dv[2] = 1;
      end
      run_query(8'h12, 8'h34, 16'h0F00, 4'b0100);
      run_query(8'h12, 8'h34, 16'hFFFF, 4'b1111);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule